// File: doc/BRIEF.md
# Scalar Float Widening Unit with Lane Merge

This block takes one IEEE-754 single-precision value and produces the exactly equal double-precision value. It writes that value into lane 0, the low 64 bits, of a wide destination vector. Normal numbers are rebiased. Subnormal inputs are normalised. Zeros, infinities and NaNs keep their sign, and every NaN comes out quiet with its payload left-aligned.

A two-bit write-mode input chooses how the rest of the destination is built.

- **Legacy mode** keeps the previous upper destination contents.
- **Merge mode** takes bits 127:64 from a first source operand and clears everything above bit 127.
- **Masked mode** does the same as merge mode and also gates the lane-0 write with a one-bit mask. When the mask is clear, lane 0 is either zeroed or left at its old value.

The block also reports a denormal-operand flag and an invalid-operation flag. Both flags are suppressed when the lane-0 write is masked off.

The caller supplies the old destination vector and the relevant slice of the first source. It pulses a valid strobe, and one cycle later a registered result appears together with a valid-out pulse. The conversion is exact, so no rounding stage exists and a rounding-mode override cannot change the result.

Top module: `fp_widen_merge`

## Requirements
- R1: For a normal input (exponent field 8'h01..8'hFE), lane 0 holds the sign, the exponent plus 896, and the 23-bit fraction placed in bits 51:29 with bits 28:0 zero.
- R2: A zero input gives a double zero of the same sign. A subnormal input (exponent 0, fraction nonzero) is normalised: with z leading zeros in the 23-bit fraction, the exponent is 896 - z and the fraction is the input fraction shifted left by z+1, dropping the leading one.
- R3: An infinity gives a double infinity of the same sign. A NaN keeps its sign, sets bit 51 (quiet), and places input fraction bits 21:0 in bits 50:29.
- R4: `denorm_o` is set for a subnormal input. `invalid_o` is set only for a signalling NaN, which has exponent 8'hFF, nonzero fraction and fraction bit 22 clear. A quiet NaN, an infinity and a normal input raise neither flag.
- R5: In mode 2'b00 (legacy), `dst_o` bits VEC_W-1:64 equal `old_dst_i` bits VEC_W-1:64, and lane 0 is always written with the converted value.
- R6: In modes 2'b01, 2'b10 and 2'b11, `dst_o` bits 127:64 equal `src1_hi_i`, and bits VEC_W-1:128 are zero.
- R7: In modes 2'b10 and 2'b11 (masked), lane 0 depends on `mask_i` and `zero_i`:
  - `mask_i`=1 writes the converted value.
  - `mask_i`=0 with `zero_i`=1 writes zero.
  - `mask_i`=0 with `zero_i`=0 keeps `old_dst_i` bits 63:0.
  - In modes 2'b00 and 2'b01, `mask_i` and `zero_i` have no effect.
- R8: When the lane-0 write is masked off (masked mode with `mask_i`=0), both flags are 0 whatever the input.
- R9: Timing and reset:
  - `dst_o` and the flags update on the clock edge that samples `valid_i`=1, and `valid_o` is 1 for exactly that following cycle.
  - While `valid_i` is 0, `dst_o` holds its value.
  - Reset clears `valid_o`, `dst_o` and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 2 | Write mode: 00 legacy, 01 merge, 1x masked |
| mask_i | input | 1 | Lane-0 write mask bit (masked mode) |
| zero_i | input | 1 | Zero lane 0 when masked off (masked mode) |
| src_i | input | 32 | Single-precision source value |
| src1_hi_i | input | 64 | First-source bits 127:64 |
| old_dst_i | input | VEC_W | Previous destination contents |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| dst_o | output | VEC_W | Merged destination vector |
| denorm_o | output | 1 | Denormal-operand flag |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The bench builds the block with the default VEC_W of 512. At that width the legacy keep span covers 448 bits and the zero-fill span covers 384 bits, so a leak of a single stray bit in either region shows up against the full-width expected vector. The conversion table reaches the ends of the subnormal range, and the count-to-exponent mapping is checked at both of its ends, 22 and 0 leading zeros. The table also covers both signs of zero, infinity and NaN and the largest finite value. Directed cases then exercise each mask and zero combination in every mode, including mode 2'b11.

// File: rtl/fpw_pkg.sv
`timescale 1ns/1ps
package fpw_pkg;
  typedef enum logic [1:0] {
    WM_LEGACY     = 2'b00,
    WM_MERGE      = 2'b01,
    WM_MASKED     = 2'b10,
    WM_MASKED_ALT = 2'b11
  } wmode_e;

  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int DP_W    = 1 + DP_EXP + DP_FRAC;
  localparam int SP_BIAS = (1 << (SP_EXP - 1)) - 1;
  localparam int DP_BIAS = (1 << (DP_EXP - 1)) - 1;
  localparam int REBIAS  = DP_BIAS - SP_BIAS;
  localparam int FR_PAD  = DP_FRAC - SP_FRAC;
endpackage

// File: rtl/fpw_lzc.sv
`timescale 1ns/1ps
module fpw_lzc #(
  parameter int W  = 23,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // scan upward; the highest set bit is assigned last and wins
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpw_convert.sv
`timescale 1ns/1ps
module fpw_convert
  import fpw_pkg::*;
(
  input  logic [SP_W-1:0] src_i,
  output logic [DP_W-1:0] res_o,
  output logic            denorm_o,
  output logic            snan_o
);
  localparam int LZW = $clog2(SP_FRAC);

  logic               sgn;
  logic [SP_EXP-1:0]  exp_s;
  logic [SP_FRAC-1:0] frac_s;
  logic               exp_zero, exp_max, frac_nz;
  logic [LZW-1:0]     lz;
  logic [LZW:0]       shamt;
  logic [SP_FRAC:0]   norm_frac;
  logic [DP_EXP-1:0]  exp_norm, exp_sub;

  assign sgn    = src_i[SP_W-1];
  assign exp_s  = src_i[SP_W-2 -: SP_EXP];
  assign frac_s = src_i[SP_FRAC-1:0];

  assign exp_zero = ~|exp_s;
  assign exp_max  = &exp_s;
  assign frac_nz  = |frac_s;

  fpw_lzc #(.W(SP_FRAC)) u_lzc (
    .vec_i (frac_s),
    .cnt_o (lz)
  );

  assign shamt     = (LZW+1)'(lz) + (LZW+1)'(1);
  assign norm_frac = {1'b0, frac_s} << shamt;
  assign exp_norm  = DP_EXP'(exp_s) + DP_EXP'(REBIAS);
  assign exp_sub   = DP_EXP'(REBIAS) - DP_EXP'(lz);

  always_comb begin
    if (exp_zero && !frac_nz) begin
      res_o = {sgn, {(DP_W-1){1'b0}}};
    end else if (exp_zero) begin
      res_o = {sgn, exp_sub, norm_frac[SP_FRAC-1:0], {FR_PAD{1'b0}}};
    end else if (exp_max && !frac_nz) begin
      res_o = {sgn, {DP_EXP{1'b1}}, {DP_FRAC{1'b0}}};
    end else if (exp_max) begin
      res_o = {sgn, {DP_EXP{1'b1}}, 1'b1, frac_s[SP_FRAC-2:0], {FR_PAD{1'b0}}};
    end else begin
      res_o = {sgn, exp_norm, frac_s, {FR_PAD{1'b0}}};
    end
  end

  assign denorm_o = exp_zero & frac_nz;
  assign snan_o   = exp_max & frac_nz & ~frac_s[SP_FRAC-1];
endmodule

// File: rtl/fpw_merge.sv
`timescale 1ns/1ps
module fpw_merge
  import fpw_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  wmode_e           mode_i,
  input  logic             mask_i,
  input  logic             zero_i,
  input  logic [DP_W-1:0]  conv_i,
  input  logic [DP_W-1:0]  src1_hi_i,
  input  logic [VEC_W-1:0] old_dst_i,
  output logic [VEC_W-1:0] dst_o,
  output logic             lane_live_o
);
  logic masked;
  logic [DP_W-1:0] lane0;

  assign masked      = (mode_i == WM_MASKED) || (mode_i == WM_MASKED_ALT);
  assign lane_live_o = !masked || mask_i;

  always_comb begin
    if (lane_live_o)  lane0 = conv_i;
    else if (zero_i)  lane0 = '0;
    else              lane0 = old_dst_i[DP_W-1:0];
  end

  always_comb begin
    dst_o = '0;
    dst_o[DP_W-1:0] = lane0;
    if (mode_i == WM_LEGACY) dst_o[VEC_W-1:DP_W] = old_dst_i[VEC_W-1:DP_W];
    else                     dst_o[2*DP_W-1:DP_W] = src1_hi_i;
  end
endmodule

// File: rtl/fp_widen_merge.sv
`timescale 1ns/1ps
module fp_widen_merge
  import fpw_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       mode_i,
  input  logic             mask_i,
  input  logic             zero_i,
  input  logic [SP_W-1:0]  src_i,
  input  logic [DP_W-1:0]  src1_hi_i,
  input  logic [VEC_W-1:0] old_dst_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] dst_o,
  output logic             denorm_o,
  output logic             invalid_o
);
  logic [DP_W-1:0]  conv;
  logic             is_denorm, is_snan, lane_live;
  logic [VEC_W-1:0] dst_d;

  fpw_convert u_conv (
    .src_i    (src_i),
    .res_o    (conv),
    .denorm_o (is_denorm),
    .snan_o   (is_snan)
  );

  fpw_merge #(.VEC_W(VEC_W)) u_merge (
    .mode_i      (wmode_e'(mode_i)),
    .mask_i      (mask_i),
    .zero_i      (zero_i),
    .conv_i      (conv),
    .src1_hi_i   (src1_hi_i),
    .old_dst_i   (old_dst_i),
    .dst_o       (dst_d),
    .lane_live_o (lane_live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      dst_o     <= '0;
      denorm_o  <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst_o     <= dst_d;
        denorm_o  <= lane_live & is_denorm;
        invalid_o <= lane_live & is_snan;
      end
    end
  end
endmodule

// File: rtl/fp_widen_merge_chk.sv
`timescale 1ns/1ps
module fp_widen_merge_chk #(
  parameter int VEC_W = 512
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       mode_i,
  input logic             mask_i,
  input logic             zero_i,
  input logic [31:0]      src_i,
  input logic [63:0]      src1_hi_i,
  input logic [VEC_W-1:0] old_dst_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] dst_o,
  input logic             denorm_o,
  input logic             invalid_o
);
  a_r9_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_valid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dst_o));
  a_r5_legacy_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b00) |=> dst_o[VEC_W-1:64] == $past(old_dst_i[VEC_W-1:64]));
  a_r6_mid_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != 2'b00) |=> dst_o[127:64] == $past(src1_hi_i));
  a_r6_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != 2'b00) |=> dst_o[VEC_W-1:128] == '0);
  a_r7_zeroing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[1] && !mask_i && zero_i) |=> dst_o[63:0] == 64'd0);
  a_r7_keep_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[1] && !mask_i && !zero_i) |=> dst_o[63:0] == $past(old_dst_i[63:0]));
  a_r8_flags_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[1] && !mask_i) |=> (!denorm_o && !invalid_o));
  a_r4_snan_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (!mode_i[1] || mask_i) && src_i[30:23] == 8'hFF
     && src_i[22:0] != 23'd0 && !src_i[22]) |=> invalid_o);
  a_r3_nan_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (!mode_i[1] || mask_i) && src_i[30:23] == 8'hFF && src_i[22:0] != 23'd0)
    |=> (dst_o[51] && dst_o[62:52] == 11'h7FF));
endmodule

bind fp_widen_merge fp_widen_merge_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .mode_i    (mode_i),
  .mask_i    (mask_i),
  .zero_i    (zero_i),
  .src_i     (src_i),
  .src1_hi_i (src1_hi_i),
  .old_dst_i (old_dst_i),
  .valid_o   (valid_o),
  .dst_o     (dst_o),
  .denorm_o  (denorm_o),
  .invalid_o (invalid_o)
);

// File: tb/tb_fp_widen_merge.sv
`timescale 1ns/1ps
module tb_fp_widen_merge;
  localparam int VEC_W = 512;
  localparam int NV = 18;
  localparam logic [VEC_W-1:0] PAT = {16{32'hDEAD_BEEF}};
  localparam logic [63:0] HI = 64'h0123_4567_89AB_CDEF;

  // {src, expected lane0, denorm, invalid}
  localparam logic [97:0] VEC [NV] = '{
    {32'h3F800000, 64'h3FF0000000000000, 1'b0, 1'b0},
    {32'hC0200000, 64'hC004000000000000, 1'b0, 1'b0},
    {32'h40490FDB, 64'h400921FB60000000, 1'b0, 1'b0},
    {32'h7F7FFFFF, 64'h47EFFFFFE0000000, 1'b0, 1'b0},
    {32'h00800000, 64'h3810000000000000, 1'b0, 1'b0},
    {32'h00000000, 64'h0000000000000000, 1'b0, 1'b0},
    {32'h80000000, 64'h8000000000000000, 1'b0, 1'b0},
    {32'h00000001, 64'h36A0000000000000, 1'b1, 1'b0},
    {32'h80000001, 64'hB6A0000000000000, 1'b1, 1'b0},
    {32'h00000003, 64'h36B8000000000000, 1'b1, 1'b0},
    {32'h00400000, 64'h3800000000000000, 1'b1, 1'b0},
    {32'h007FFFFF, 64'h380FFFFFC0000000, 1'b1, 1'b0},
    {32'h7F800000, 64'h7FF0000000000000, 1'b0, 1'b0},
    {32'hFF800000, 64'hFFF0000000000000, 1'b0, 1'b0},
    {32'h7FC00000, 64'h7FF8000000000000, 1'b0, 1'b0},
    {32'hFFC00001, 64'hFFF8000020000000, 1'b0, 1'b0},
    {32'h7F800001, 64'h7FF8000020000000, 1'b0, 1'b1},
    {32'hFF80ABCD, 64'hFFF81579A0000000, 1'b0, 1'b1}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [1:0]       mode_i = 2'b00;
  logic             mask_i = 1'b0;
  logic             zero_i = 1'b0;
  logic [31:0]      src_i = '0;
  logic [63:0]      src1_hi_i = '0;
  logic [VEC_W-1:0] old_dst_i = '0;
  logic             valid_o;
  logic [VEC_W-1:0] dst_o;
  logic             denorm_o, invalid_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fp_widen_merge #(.VEC_W(VEC_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .mask_i(mask_i), .zero_i(zero_i), .src_i(src_i), .src1_hi_i(src1_hi_i),
    .old_dst_i(old_dst_i), .valid_o(valid_o), .dst_o(dst_o),
    .denorm_o(denorm_o), .invalid_o(invalid_o)
  );

  task automatic chk(input string tag, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one op; returns after the result register has loaded
  task automatic do_op(input logic [1:0] m, input logic mk, input logic z,
                       input logic [31:0] s, input logic [63:0] hi, input logic [VEC_W-1:0] od);
    @(negedge clk_i);
    mode_i = m; mask_i = mk; zero_i = z; src_i = s; src1_hi_i = hi; old_dst_i = od;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  function automatic string tag_of(input logic [31:0] s);
    if (s[30:23] == 8'h00) return "R2 lane0";
    if (s[30:23] == 8'hFF) return "R3 lane0";
    return "R1 lane0";
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R9 reset valid", VEC_W'(valid_o), '0);
    chk("R9 reset dst", dst_o, '0);
    chk("R9 reset flags", VEC_W'({denorm_o, invalid_o}), '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(2'b01, 1'b1, 1'b0, VEC[i][97:66], HI, PAT);
      chk(tag_of(VEC[i][97:66]), VEC_W'(dst_o[63:0]), VEC_W'(VEC[i][65:2]));
      chk("R4 denorm flag", VEC_W'(denorm_o), VEC_W'(VEC[i][1]));
      chk("R4 invalid flag", VEC_W'(invalid_o), VEC_W'(VEC[i][0]));
      chk("R6 upper fill", dst_o[VEC_W-1:64], {{(VEC_W-128){1'b0}}, HI});
    end

    // legacy
    do_op(2'b00, 1'b1, 1'b0, 32'h3F800000, HI, PAT);
    chk("R5 legacy keep", dst_o, {PAT[VEC_W-1:64], 64'h3FF0000000000000});
    chk("R9 valid_o pulse", VEC_W'(valid_o), VEC_W'(1));
    @(negedge clk_i);
    chk("R9 valid_o drops", VEC_W'(valid_o), '0);

    // mask/zero ignored outside masked modes
    do_op(2'b00, 1'b0, 1'b1, 32'hC0200000, HI, PAT);
    chk("R7 legacy ignores mask", dst_o, {PAT[VEC_W-1:64], 64'hC004000000000000});
    do_op(2'b01, 1'b0, 1'b1, 32'h00000001, HI, PAT);
    chk("R7 merge ignores mask", dst_o, {{(VEC_W-128){1'b0}}, HI, 64'h36A0000000000000});
    chk("R4 flag in merge mode", VEC_W'(denorm_o), VEC_W'(1));

    // masked mode
    do_op(2'b10, 1'b1, 1'b0, 32'h3F800000, HI, PAT);
    chk("R7 masked write", dst_o, {{(VEC_W-128){1'b0}}, HI, 64'h3FF0000000000000});
    do_op(2'b10, 1'b0, 1'b1, 32'h00000001, HI, PAT);
    chk("R7 masked zeroing", dst_o, {{(VEC_W-128){1'b0}}, HI, 64'h0});
    chk("R8 denorm suppressed", VEC_W'(denorm_o), '0);
    do_op(2'b10, 1'b0, 1'b0, 32'h7F800001, HI, PAT);
    chk("R7 masked keep old", dst_o, {{(VEC_W-128){1'b0}}, HI, PAT[63:0]});
    chk("R8 invalid suppressed", VEC_W'(invalid_o), '0);
    do_op(2'b11, 1'b1, 1'b1, 32'h7F800001, HI, PAT);
    chk("R7 mode 11 write", dst_o, {{(VEC_W-128){1'b0}}, HI, 64'h7FF8000020000000});
    chk("R4 invalid in mode 11", VEC_W'(invalid_o), VEC_W'(1));
    do_op(2'b11, 1'b0, 1'b0, 32'h3F800000, 64'h0, PAT);
    chk("R7 mode 11 keep old", dst_o, {{(VEC_W-64){1'b0}}, PAT[63:0]});

    // hold while idle
    @(negedge clk_i);
    src_i = 32'h40490FDB; mode_i = 2'b00; old_dst_i = ~PAT;
    repeat (3) @(negedge clk_i);
    chk("R9 hold when idle", dst_o, {{(VEC_W-64){1'b0}}, PAT[63:0]});

    // asynchronous reset mid-run
    do_op(2'b00, 1'b1, 1'b0, 32'h3F800000, HI, PAT);
    #1 rst_ni = 1'b0;
    #1;
    chk("R9 reset clears dst", dst_o, '0);
    chk("R9 reset clears valid", VEC_W'(valid_o), '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog expired act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule